// File: doc/BRIEF.md
# GPIO Pin Configuration Bank

This block holds one 32-bit configuration word per GPIO pin behind a simple register read/write port. Each word chooses whether the pin drives or only listens, and which interrupt trigger applies when it listens. It also picks whether the pad belongs to plain GPIO or to one of three peripherals, and holds the output data bit. The bank drives each pad's output and output-enable, and it returns the live, synchronized pad level when software reads a pin that is not driving.

Pull, drive-strength, Schmitt and input-enable settings are exported as static pad controls. The interrupt mode, the interrupt group and the synchronized pad level are exported to a separate edge/level detection block. A lock bit freezes a pin's word until the next reset.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every configuration word is zero, every `padOe` bit is 0, and a read of any pin returns 0 while its pad is low.
- R2: Pin n's word sits at byte address 4*n, and address bits 1:0 are ignored. Read data appears on `busRdData` with `busRdValid` high in the cycle after `busRdEn` is sampled. Word indices from NUM_PINS up to the end of the 512-word space read as 0, and writes to them change nothing.
- R3: A write stores only the defined bits: mask 0x00E78FEF. These are data bit 0, mode bits 3:1, function bits 6:5, pull bits 8:7, input enable bit 9, drive bits 11:10 and 23:22, Schmitt bit 15, group bits 18:16 and lock bit 21. Every other bit reads back as 0.
- R4: With mode 1 (output) and function 0, `padOe` is 1 and `padOut` equals the stored data bit. With any other mode and function 0, `padOe` is 0.
- R5: In a read, bit 0 is the stored data bit when the mode is 1, and the synchronized pad level for any other mode.
- R6: The pad input passes through two flops before reads see it. A read sampled in the first or second clock edge after a pad change returns the old level, and a read sampled in the third edge returns the new one.
- R7: With function f in 1..3, `padOut[n]` and `padOe[n]` take `periphOut[3n+f-1]` and `periphOe[3n+f-1]`.
- R8: `periphIn[3n+f-1]` carries the synchronized pad level only when pin n's function is f and input enable (bit 9) is set. Otherwise it is 0.
- R9: Once a pin's stored lock bit is 1, writes to that pin are ignored until reset.
- R10: `padPull`, `padDrive0`, `padDrive1`, `padSchmitt`, `padInEn` and `irqGroup` export bits 8:7, 11:10, 23:22, 15, 9 and 18:16 of each pin's word. Each export uses the pin's own slice.
- R11: `irqMode` exports each pin's mode field (2 level-high, 3 level-low, 4 rising, 5 falling, 6 any edge, 7 input with interrupts off). A stored mode of 0 is exported as 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| busRdValid | output | 1 | Read data valid |
| padIn | input | NUM_PINS | Raw pad levels |
| padOut | output | NUM_PINS | Pad output values |
| padOe | output | NUM_PINS | Pad output enables |
| periphOut | input | 3*NUM_PINS | Peripheral outputs, 3 per pin |
| periphOe | input | 3*NUM_PINS | Peripheral output enables, 3 per pin |
| periphIn | output | 3*NUM_PINS | Synchronized pad level routed to peripherals |
| padPull | output | 2*NUM_PINS | Pull setting per pin |
| padDrive0 | output | 2*NUM_PINS | First drive-strength field per pin |
| padDrive1 | output | 2*NUM_PINS | Second drive-strength field per pin |
| padSchmitt | output | NUM_PINS | Schmitt enable per pin |
| padInEn | output | NUM_PINS | Input enable per pin |
| irqMode | output | 3*NUM_PINS | Normalized interrupt mode per pin |
| irqGroup | output | 3*NUM_PINS | Interrupt group per pin |
| irqLevel | output | NUM_PINS | Synchronized pad level per pin |

## Verification
The pins are exercised in three patterns: driving with function 0, listening in several modes, and handing the pad to a peripheral. The first pattern separates stored-bit readback from live-level readback. The second catches a wrong mode-field decode. The third catches an off-by-one peripheral slot and missing input gating. An all-ones write with the lock bit clear exposes the mask and every static export at once. Back-to-back reads right after a pad change separate a two-flop synchronizer from a one-flop one. Out-of-range and locked-pin writes are followed by reads that would show any leaked state.

// File: rtl/gpio_pin_bank_pkg.sv
package gpio_pin_bank_pkg;

  localparam int NUM_FUNC = 3;
  localparam logic [31:0] CFG_MASK = 32'h00E7_8FEF;
  localparam int LOCK_BIT = 21;
  localparam int INEN_BIT = 9;

  typedef enum logic [2:0] {
    MODE_UNSET  = 3'd0,
    MODE_OUT    = 3'd1,
    MODE_LVL_HI = 3'd2,
    MODE_LVL_LO = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_BOTH   = 3'd6,
    MODE_IN_OFF = 3'd7
  } pinMode_e;

  typedef struct packed {
    logic wr;   // write strobe
    logic rd;   // read strobe
    logic hit;  // address falls on an implemented pin
  } busStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 11,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb,
  output logic [PIN_W-1:0]  pinIdx,
  output logic              rdValid
);

  logic [WORD_W-1:0] wordIdx;
  logic              addrUnused;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign addrUnused = ^busAddr[1:0];
  assign pinIdx     = wordIdx[PIN_W-1:0];

  always_comb begin
    strb.wr  = busWrEn;
    strb.rd  = busRdEn;
    strb.hit = (wordIdx < WORD_W'(NUM_PINS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRdEn;
  end

  // R2: read data valid exactly one cycle after the strobe
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> rdValid);
  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !rdValid);

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strb,
  input  logic [PIN_W-1:0]         pinIdx,
  input  logic [31:0]              wrData,
  input  logic [NUM_PINS-1:0]      padIn,
  input  logic [NUM_FUNC*NUM_PINS-1:0] periphOut,
  input  logic [NUM_FUNC*NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0]      padOut,
  output logic [NUM_PINS-1:0]      padOe,
  output logic [NUM_FUNC*NUM_PINS-1:0] periphIn,
  output logic [2*NUM_PINS-1:0]    padPull,
  output logic [2*NUM_PINS-1:0]    padDrive0,
  output logic [2*NUM_PINS-1:0]    padDrive1,
  output logic [NUM_PINS-1:0]      padSchmitt,
  output logic [NUM_PINS-1:0]      padInEn,
  output logic [3*NUM_PINS-1:0]    irqMode,
  output logic [3*NUM_PINS-1:0]    irqGroup,
  output logic [NUM_PINS-1:0]      padSync,
  output logic [31:0]              rdData
);

  logic [31:0] rdWord [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int PB = i * NUM_FUNC;

    logic [31:0] cfgQ;
    logic        meta1Q;
    logic        sync2Q;
    logic        wrSel;
    pinMode_e    mode;
    logic [1:0]  func;
    logic        isOut;

    assign wrSel = strb.wr && strb.hit && (pinIdx == PIN_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        cfgQ <= '0;
      else if (wrSel && !cfgQ[LOCK_BIT]) cfgQ <= wrData & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta1Q <= 1'b0;
        sync2Q <= 1'b0;
      end else begin
        meta1Q <= padIn[i];
        sync2Q <= meta1Q;
      end
    end

    assign mode  = pinMode_e'(cfgQ[3:1]);
    assign func  = cfgQ[6:5];
    assign isOut = (mode == MODE_OUT);

    always_comb begin
      case (func)
        2'd0: begin
          padOut[i] = isOut & cfgQ[0];
          padOe[i]  = isOut;
        end
        2'd1: begin
          padOut[i] = periphOut[PB];
          padOe[i]  = periphOe[PB];
        end
        2'd2: begin
          padOut[i] = periphOut[PB + 1];
          padOe[i]  = periphOe[PB + 1];
        end
        default: begin
          padOut[i] = periphOut[PB + 2];
          padOe[i]  = periphOe[PB + 2];
        end
      endcase
    end

    for (genvar k = 0; k < NUM_FUNC; k++) begin : g_fn
      assign periphIn[PB + k] = sync2Q & cfgQ[INEN_BIT] & (func == 2'(k + 1));
    end

    assign padPull[2*i +: 2]   = cfgQ[8:7];
    assign padDrive0[2*i +: 2] = cfgQ[11:10];
    assign padDrive1[2*i +: 2] = cfgQ[23:22];
    assign padSchmitt[i]       = cfgQ[15];
    assign padInEn[i]          = cfgQ[INEN_BIT];
    assign irqGroup[3*i +: 3]  = cfgQ[18:16];
    assign irqMode[3*i +: 3]   = (mode == MODE_UNSET) ? MODE_IN_OFF : mode;
    assign padSync[i]          = sync2Q;
    assign rdWord[i]           = {cfgQ[31:1], isOut ? cfgQ[0] : sync2Q};

    // R9: a locked word never changes
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      $past(cfgQ[LOCK_BIT]) |-> $stable(cfgQ));
    // R3: an accepted write lands masked
    p_write_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
      $past(wrSel && !cfgQ[LOCK_BIT]) |-> (cfgQ == ($past(wrData) & CFG_MASK)));
    // R11: detection block never sees the unset code
    p_mode_norm_r11: assert property (@(posedge clk) disable iff (!rstN)
      irqMode[3*i +: 3] != 3'd0);
    // R8: peripheral inputs stay quiet without input enable
    p_periph_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      !padInEn[i] |-> (periphIn[PB +: NUM_FUNC] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (strb.rd) rdData <= strb.hit ? rdWord[pinIdx] : 32'd0;
  end

  // R2: unimplemented words read as zero
  p_oor_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !strb.hit) |=> (rdData == 32'd0));

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 11,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int FN_W    = NUM_FUNC * NUM_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic                  busRdValid,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  input  logic [FN_W-1:0]       periphOut,
  input  logic [FN_W-1:0]       periphOe,
  output logic [FN_W-1:0]       periphIn,
  output logic [2*NUM_PINS-1:0] padPull,
  output logic [2*NUM_PINS-1:0] padDrive0,
  output logic [2*NUM_PINS-1:0] padDrive1,
  output logic [NUM_PINS-1:0]   padSchmitt,
  output logic [NUM_PINS-1:0]   padInEn,
  output logic [3*NUM_PINS-1:0] irqMode,
  output logic [3*NUM_PINS-1:0] irqGroup,
  output logic [NUM_PINS-1:0]   irqLevel
);

  busStrobe_t       strb;
  logic [PIN_W-1:0] pinIdx;

  gpio_bank_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb),
    .pinIdx  (pinIdx),
    .rdValid (busRdValid)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pinIdx     (pinIdx),
    .wrData     (busWrData),
    .padIn      (padIn),
    .periphOut  (periphOut),
    .periphOe   (periphOe),
    .padOut     (padOut),
    .padOe      (padOe),
    .periphIn   (periphIn),
    .padPull    (padPull),
    .padDrive0  (padDrive0),
    .padDrive1  (padDrive1),
    .padSchmitt (padSchmitt),
    .padInEn    (padInEn),
    .irqMode    (irqMode),
    .irqGroup   (irqGroup),
    .padSync    (irqLevel),
    .rdData     (busRdData)
  );

endmodule

// File: tb/gpio_pin_bank_test.sv
module gpio_pin_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int AW = 11;
  localparam int FN = 3 * N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          busRdValid;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  padOut, padOe;
  logic [FN-1:0] periphOut = '0;
  logic [FN-1:0] periphOe = '0;
  logic [FN-1:0] periphIn;
  logic [2*N-1:0] padPull, padDrive0, padDrive1;
  logic [N-1:0]  padSchmitt, padInEn, irqLevel;
  logic [3*N-1:0] irqMode, irqGroup;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] monExp;
  string       monTag;
  bit          done = 1'b0;

  gpio_pin_bank #(.NUM_PINS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .periphOut(periphOut), .periphOe(periphOe), .periphIn(periphIn),
    .padPull(padPull), .padDrive0(padDrive0), .padDrive1(padDrive1),
    .padSchmitt(padSchmitt), .padInEn(padInEn), .irqMode(irqMode),
    .irqGroup(irqGroup), .irqLevel(irqLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected read valid", 32'd1, 32'd0);
      end else begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        check(monTag, busRdData, monExp);
      end
    end
  end

  task automatic doWrite(int word, logic [31:0] d);
    busAddr   = AW'(word * 4);
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic doRead(int word, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busAddr = AW'(word * 4);
    busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      check("watchdog expired", 32'd1, 32'd0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 padOe after reset", 32'(padOe), 32'd0);
    check("R1 irqMode pin0 after reset", 32'(irqMode[2:0]), 32'd7);
    doRead(0, 32'd0, "R1 pin0 reads zero");

    // R4/R5: output mode, function 0
    doWrite(3, 32'h0000_0003);
    check("R4 padOe pin3", 32'(padOe[3]), 32'd1);
    check("R4 padOut pin3", 32'(padOut[3]), 32'd1);
    doRead(3, 32'h0000_0003, "R5 stored data in output mode");
    doRead(4, 32'd0, "R2 neighbour pin4 untouched");
    doWrite(3, 32'h0000_0002);
    check("R4 padOut follows data 0", 32'(padOut[3]), 32'd0);
    check("R4 padOe still set", 32'(padOe[3]), 32'd1);

    // R6/R5: synchronizer latency on pin 5 (mode 0)
    padIn[5] = 1'b1;
    doRead(5, 32'd0, "R6 first edge stale");
    doRead(5, 32'd0, "R6 second edge stale");
    doRead(5, 32'd1, "R5 live level after sync");
    check("R4 padOe off in input mode", 32'(padOe[5]), 32'd0);

    // R3/R10: all-ones except lock on pin 7
    doWrite(7, 32'hFFDF_FFFF);
    doRead(7, 32'h00C7_8FEE, "R3 masked readback");
    check("R10 pull", 32'(padPull[15:14]), 32'd3);
    check("R10 drive0", 32'(padDrive0[15:14]), 32'd3);
    check("R10 drive1", 32'(padDrive1[15:14]), 32'd3);
    check("R10 schmitt", 32'(padSchmitt[7]), 32'd1);
    check("R10 input enable", 32'(padInEn[7]), 32'd1);
    check("R10 group", 32'(irqGroup[23:21]), 32'd7);
    check("R10 neighbour pull", 32'(padPull[13:12]), 32'd0);

    // R7: function 3 on pin 7 uses slot 23
    periphOut[23] = 1'b1;
    periphOe[23]  = 1'b1;
    #1;
    check("R7 padOut from periph 3", 32'(padOut[7]), 32'd1);
    check("R7 padOe from periph 3", 32'(padOe[7]), 32'd1);
    periphOe[23] = 1'b0;
    periphOe[21] = 1'b1;
    #1;
    check("R7 unselected periph ignored", 32'(padOe[7]), 32'd0);
    @(negedge clk);

    // R8: routed input
    padIn[7] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 selected periph input", 32'(periphIn[23]), 32'd1);
    check("R8 unselected periph inputs", 32'(periphIn[22:21]), 32'd0);
    doRead(7, 32'h00C7_8FEF, "R5 live level pin7");
    doWrite(7, 32'h0000_0060);
    check("R8 input enable clear", 32'(periphIn[23]), 32'd0);
    check("R11 mode 0 exported as 7", 32'(irqMode[23:21]), 32'd7);
    doWrite(7, 32'h0000_0208);
    check("R11 rising mode", 32'(irqMode[23:21]), 32'd4);
    check("R8 function 0 no periph input", 32'(periphIn[23:21]), 32'd0);
    doWrite(7, 32'h0000_0004);
    check("R11 level-high mode", 32'(irqMode[23:21]), 32'd2);

    // R9: lock
    doWrite(9, 32'h0020_0003);
    doWrite(9, 32'h0000_0000);
    doRead(9, 32'h0020_0003, "R9 locked word unchanged");
    check("R9 padOe still driven", 32'(padOe[9]), 32'd1);

    // R2: addressing edges
    doWrite(100, 32'hFFFF_FFFF);
    doRead(100, 32'd0, "R2 out of range word");
    doRead(511, 32'd0, "R2 last word of space");
    doWrite(31, 32'h0000_0002);
    doRead(31, 32'h0000_0002, "R2 last pin");
    check("R2 last pin padOe", 32'(padOe[31]), 32'd1);
    busAddr = AW'(31 * 4 + 3);
    busRdEn = 1'b1;
    expQ.push_back(32'h0000_0002);
    tagQ.push_back("R2 low address bits ignored");
    @(negedge clk);
    busRdEn = 1'b0;

    repeat (2) @(negedge clk);
    check("R2 all reads returned", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule